// File: doc/BRIEF.md
# Register Window Controller

This block keeps sixteen visible data registers on top of a larger physical register file whose size is a parameter. The physical file is split into groups of four, and the visible window starts at a base group that is stored modulo the group count. A bitmap holds one bit per group. A set bit marks the group where a live call frame begins. Visible register k always resolves to physical entry (base*4 + k) modulo the file size. Reads are combinational through this mapping. A write through the visible port lands on the mapped physical entry at the clock edge.

The instruction side of the pipeline presents one operation per cycle as a strobe with its operands. The operations are: call-entry, windowed return, relative rotate, a stack-move legality check, and restoring the base from the saved old-base field. The controller updates the base and the bitmap. It computes the new stack pointer on entry and forms the return address on return. It also classifies what went wrong: an illegal instruction, a stack-allocation fault, or a window overflow or underflow with a size of 4, 8 or 12 registers. It does this by scanning the circular bitmap relative to the current base. On a window overflow or underflow it reports the old base, so the exception logic can store it, and it flags that the exception-mode bit must be set.

Top module: `regwin_ctrl`

## Requirements
- R1: Visible register k (0..15) reads physical entry (base*4+k) mod NAREG combinationally. A write with wr_en lands on that entry at the next rising edge. The base wraps modulo NAREG/4.
- R2: After reset the base is 0, the bitmap holds only group 0, every physical entry is 0, op_done is 0, exc_code is 0 and excm_set is 0.
- R3: Entry (op_kind 1) is refused with exc_code 1 when op_reg > 3, when ps_woe is 0 or when ps_excm is 1. The base and the bitmap do not change.
- R4: A legal entry with no overflow writes a[ps_callinc*4 + op_reg] = a[op_reg] − op_imm*8, indexed in the old window. It then adds ps_callinc to the base and sets the bitmap bit of the new base.
- R5: Let B be the bitmap rotated so that bit 0 is the group just above the base. A legal entry overflows when any of the low ps_callinc bits of B is set. It then writes no register, moves the base forward by n = 1 + (trailing zeros of B), reports the old base on owb_save and pulses excm_set.
- R6: The overflow size comes from the trailing-zero count of B rotated by a further n. A count of 0 gives exc_code 3 (4 registers), 1 gives 4 (8 registers), and any other count gives 5 (12 registers).
- R7: Return (op_kind 2) takes n from a0[31:30]. It takes m as 1, 2 or 3 for the nearest set bitmap bit at base−1, base−2 or base−3, or 0 if none of them is set. The return is refused with exc_code 1, with no state change, when n is 0, when m is nonzero and differs from n, or unless ps_woe=1 and ps_excm=0.
- R8: A legal return sets ret_pc = {op_pc_hi, a0[29:0]} and subtracts n from the base. If the bitmap bit of the new base is set, it clears the bit of the old base.
- R9: If that bit is clear, the return underflows. The bitmap is kept, owb_save shows the old base, excm_set pulses, and exc_code is 6, 7 or 8 for n = 1, 2 or 3.
- R10: Stack-move check (op_kind 4) gives exc_code 2 when the bitmap bits at base−1, base−2 and base−3 are all clear, and 0 otherwise. Nothing else changes.
- R11: Rotate (op_kind 3) adds the sign-extended 4-bit op_rot to the base. Restore (op_kind 5) loads the base from ps_owb. Other op_kind values change nothing.
- R12: op_done is high exactly in the cycle after an op_valid cycle. exc_code and excm_set are valid in that cycle and are 0 in every cycle without op_done.
- R13: wr_en is ignored in any cycle where op_valid is high.
- R14: The bitmap is never all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_idx | input | 4 | Visible register to read |
| rd_data | output | DW | Content of the visible register rd_idx |
| wr_en | input | 1 | Write the visible register wr_idx |
| wr_idx | input | 4 | Visible register to write |
| wr_data | input | DW | Write data |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 3 | 1 entry, 2 return, 3 rotate, 4 stack-move check, 5 restore |
| op_reg | input | 4 | Register operand of entry |
| op_imm | input | IMM_W | Frame size of entry, in units of 8 |
| op_rot | input | 4 | Signed rotate amount, in groups |
| op_pc_hi | input | 2 | Upper two PC bits of the return instruction |
| ps_woe | input | 1 | Window-overflow enable field of the status word |
| ps_excm | input | 1 | Exception-mode field of the status word |
| ps_callinc | input | 2 | Call increment field of the status word |
| ps_owb | input | BW | Saved old-base field of the status word |
| op_done | output | 1 | Operation finished, one cycle after the strobe |
| exc_code | output | 4 | Outcome code, 0 for none |
| ret_pc | output | DW | Return address from the last legal return |
| owb_save | output | BW | Old base recorded at the last overflow or underflow |
| excm_set | output | 1 | Pulse: set the exception-mode field |
| win_base | output | BW | Current base group |
| win_start | output | NAREG/4 | Current frame-start bitmap |

## Verification
Register reads settle in the same cycle as a base change, with no clock in between. Every operation outcome (op_done, exc_code, excm_set, ret_pc, owb_save, and the new base and bitmap) is registered once and so appears one cycle after the strobe. The bench drives each strobe or write on a falling edge and withdraws it on the next falling edge. It samples all outcomes at that second falling edge, which is half a period after the single rising edge that consumed the stimulus. Combinational reads are taken a short delay after the falling edge. The op_done pulse is checked for its drop one cycle later.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ENTRY   = 3'd1,
    OP_RETW    = 3'd2,
    OP_ROTW    = 3'd3,
    OP_MOVSP   = 3'd4,
    OP_RESTORE = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    EX_NONE    = 4'd0,
    EX_ILLEGAL = 4'd1,
    EX_ALLOCA  = 4'd2,
    EX_OVF4    = 4'd3,
    EX_OVF8    = 4'd4,
    EX_OVF12   = 4'd5,
    EX_UNF4    = 4'd6,
    EX_UNF8    = 4'd7,
    EX_UNF12   = 4'd8
  } exc_e;

endpackage

// File: rtl/regwin_phys.sv
module regwin_phys #(
  parameter int NAREG = 64,
  parameter int DW    = 32,
  parameter int NRD   = 3,
  localparam int GROUPS = NAREG / 4,
  localparam int BW     = $clog2(GROUPS),
  localparam int PW     = $clog2(NAREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BW-1:0]            base,
  input  logic [NRD-1:0][3:0]      rd_idx,
  output logic [NRD-1:0][DW-1:0]   rd_data,
  input  logic                     wr_go,
  input  logic [3:0]               wr_vidx,
  input  logic [DW-1:0]            wr_val
);

  logic [DW-1:0] mem [NAREG];

  // visible index -> physical index, wrapping at the file size
  function automatic logic [PW-1:0] phys_of(input logic [BW-1:0] b, input logic [3:0] k);
    logic [PW-1:0] s;
    s = PW'({b, 2'b00}) + PW'(k);
    return s;
  endfunction

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[phys_of(base, rd_idx[p])];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NAREG; i++) mem[i] <= '0;
    end else if (wr_go) begin
      mem[phys_of(base, wr_vidx)] <= wr_val;
    end
  end

endmodule

// File: rtl/regwin_scan.sv
module regwin_scan
  import regwin_pkg::*;
#(
  parameter int GROUPS = 16,
  localparam int BW = $clog2(GROUPS)
) (
  input  logic [BW-1:0]     base,
  input  logic [GROUPS-1:0] ws,
  input  logic [1:0]        callinc,
  output logic              ovf_hit,
  output logic [1:0]        ovf_n,
  output exc_e              ovf_kind,
  output logic [1:0]        near_m
);

  function automatic int unsigned ctz(input logic [GROUPS-1:0] v);
    int unsigned r;
    r = GROUPS;
    for (int i = GROUPS - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  logic [GROUPS-1:0] above;   // bitmap seen from the group just above base
  logic [GROUPS-1:0] rest;    // bitmap seen from the first frame found
  logic [GROUPS-1:0] ci_mask;
  int unsigned       first_tz;
  int unsigned       rest_tz;

  for (genvar i = 0; i < GROUPS; i++) begin : g_above
    assign above[i] = ws[base + BW'(i + 1)];
  end

  assign ci_mask  = GROUPS'((1 << callinc) - 1);
  assign ovf_hit  = (above & ci_mask) != '0;
  assign first_tz = ctz(above);
  assign ovf_n    = 2'(first_tz + 1);

  for (genvar i = 0; i < GROUPS; i++) begin : g_rest
    assign rest[i] = above[BW'(i) + BW'(ovf_n)];
  end

  assign rest_tz = ctz(rest);

  always_comb begin
    unique case (rest_tz)
      0:       ovf_kind = EX_OVF4;
      1:       ovf_kind = EX_OVF8;
      default: ovf_kind = EX_OVF12;
    endcase
  end

  always_comb begin
    if (ws[base - BW'(1)])      near_m = 2'd1;
    else if (ws[base - BW'(2)]) near_m = 2'd2;
    else if (ws[base - BW'(3)]) near_m = 2'd3;
    else                        near_m = 2'd0;
  end

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int NAREG = 64,
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  localparam int GROUPS = NAREG / 4,
  localparam int BW     = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_idx,
  output logic [DW-1:0]     rd_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [3:0]        op_reg,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic [3:0]        op_rot,
  input  logic [1:0]        op_pc_hi,
  input  logic              ps_woe,
  input  logic              ps_excm,
  input  logic [1:0]        ps_callinc,
  input  logic [BW-1:0]     ps_owb,
  output logic              op_done,
  output logic [3:0]        exc_code,
  output logic [DW-1:0]     ret_pc,
  output logic [BW-1:0]     owb_save,
  output logic              excm_set,
  output logic [BW-1:0]     win_base,
  output logic [GROUPS-1:0] win_start
);

  logic [BW-1:0]     base_q, base_d;
  logic [GROUPS-1:0] ws_q, ws_d;
  exc_e              exc_q, exc_d;
  logic              excm_q, excm_d;
  logic [BW-1:0]     owb_q, owb_d;
  logic [DW-1:0]     retpc_q, retpc_d;
  logic              done_q;

  logic              wr_go;
  logic [3:0]        wr_vidx;
  logic [DW-1:0]     wr_val;

  logic [2:0][3:0]    rd_idx_v;
  logic [2:0][DW-1:0] rd_data_v;
  logic [DW-1:0]      src_val;
  logic [DW-1:0]      a0_val;

  logic              ovf_hit;
  logic [1:0]        ovf_n;
  exc_e              ovf_kind;
  logic [1:0]        near_m;

  // named events for observation
  logic              ev_entry_ok;
  logic              ev_retw_ok;
  logic              ev_overflow;
  logic              ev_underflow;
  logic [1:0]        ret_n;
  logic [BW-1:0]     ret_base;

  function automatic logic [BW-1:0] sext_rot(input logic [3:0] r);
    logic [BW+3:0] t;
    t = {{BW{r[3]}}, r};
    return t[BW-1:0];
  endfunction

  function automatic exc_e unf_code(input logic [1:0] n);
    unique case (n)
      2'd1:    return EX_UNF4;
      2'd2:    return EX_UNF8;
      default: return EX_UNF12;
    endcase
  endfunction

  assign rd_idx_v[0] = rd_idx;
  assign rd_idx_v[1] = op_reg;
  assign rd_idx_v[2] = 4'd0;
  assign rd_data     = rd_data_v[0];
  assign src_val     = rd_data_v[1];
  assign a0_val      = rd_data_v[2];

  regwin_phys #(.NAREG(NAREG), .DW(DW), .NRD(3)) i_phys (
    .clk     (clk),
    .rst_n   (rst_n),
    .base    (base_q),
    .rd_idx  (rd_idx_v),
    .rd_data (rd_data_v),
    .wr_go   (wr_go),
    .wr_vidx (wr_vidx),
    .wr_val  (wr_val)
  );

  regwin_scan #(.GROUPS(GROUPS)) i_scan (
    .base     (base_q),
    .ws       (ws_q),
    .callinc  (ps_callinc),
    .ovf_hit  (ovf_hit),
    .ovf_n    (ovf_n),
    .ovf_kind (ovf_kind),
    .near_m   (near_m)
  );

  assign ret_n       = a0_val[DW-1:DW-2];
  assign ret_base    = base_q - BW'(ret_n);
  assign ev_entry_ok = (op_reg <= 4'd3) && ps_woe && !ps_excm;
  assign ev_retw_ok  = (ret_n != 2'd0) && (near_m == 2'd0 || near_m == ret_n)
                       && ps_woe && !ps_excm;
  assign ev_overflow  = op_valid && op_kind == OP_ENTRY && ev_entry_ok && ovf_hit;
  assign ev_underflow = op_valid && op_kind == OP_RETW && ev_retw_ok && !ws_q[ret_base];

  always_comb begin
    base_d  = base_q;
    ws_d    = ws_q;
    exc_d   = EX_NONE;
    excm_d  = 1'b0;
    owb_d   = owb_q;
    retpc_d = retpc_q;
    wr_go   = wr_en && !op_valid;
    wr_vidx = wr_idx;
    wr_val  = wr_data;
    if (op_valid) begin
      unique case (op_kind)
        OP_ENTRY: begin
          if (!ev_entry_ok) begin
            exc_d = EX_ILLEGAL;
          end else if (ovf_hit) begin
            base_d = base_q + BW'(ovf_n);
            owb_d  = base_q;
            excm_d = 1'b1;
            exc_d  = ovf_kind;
          end else begin
            wr_go   = 1'b1;
            wr_vidx = {ps_callinc, op_reg[1:0]};
            wr_val  = src_val - (DW'(op_imm) << 3);
            base_d  = base_q + BW'(ps_callinc);
            ws_d[base_d] = 1'b1;
          end
        end
        OP_RETW: begin
          if (!ev_retw_ok) begin
            exc_d = EX_ILLEGAL;
          end else begin
            retpc_d = {op_pc_hi, a0_val[DW-3:0]};
            base_d  = ret_base;
            if (ws_q[ret_base]) begin
              ws_d[base_q] = 1'b0;
            end else begin
              owb_d  = base_q;
              excm_d = 1'b1;
              exc_d  = unf_code(ret_n);
            end
          end
        end
        OP_ROTW:    base_d = base_q + sext_rot(op_rot);
        OP_MOVSP:   if (near_m == 2'd0) exc_d = EX_ALLOCA;
        OP_RESTORE: base_d = ps_owb;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      ws_q    <= GROUPS'(1);
      exc_q   <= EX_NONE;
      excm_q  <= 1'b0;
      owb_q   <= '0;
      retpc_q <= '0;
      done_q  <= 1'b0;
    end else begin
      base_q  <= base_d;
      ws_q    <= ws_d;
      exc_q   <= exc_d;
      excm_q  <= excm_d;
      owb_q   <= owb_d;
      retpc_q <= retpc_d;
      done_q  <= op_valid;
    end
  end

  assign op_done   = done_q;
  assign exc_code  = exc_q;
  assign excm_set  = excm_q;
  assign owb_save  = owb_q;
  assign ret_pc    = retpc_q;
  assign win_base  = base_q;
  assign win_start = ws_q;

endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int GROUPS = 16,
  localparam int BW = $clog2(GROUPS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              op_done,
  input logic [3:0]        exc_code,
  input logic              excm_set,
  input logic [BW-1:0]     win_base,
  input logic [GROUPS-1:0] win_start
);

  // R12
  done_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> op_done);

  // R12
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !op_done);

  // R12
  exc_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code != 4'd0) |-> op_done);

  // R5 R9
  excm_window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    excm_set |-> (exc_code >= 4'd3 && exc_code <= 4'd8));

  // R3 R7 R10
  refused_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code == 4'd1 || exc_code == 4'd2) |-> ($stable(win_base) && $stable(win_start)));

  // R11
  idle_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(win_base));

  // R14
  ws_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_start != '0);

endmodule

bind regwin_ctrl regwin_chk #(.GROUPS(GROUPS)) i_regwin_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_done   (op_done),
  .exc_code  (exc_code),
  .excm_set  (excm_set),
  .win_base  (win_base),
  .win_start (win_start)
);

// File: tb/test_regwin_ctrl.sv
`timescale 1ns/1ps
module test_regwin_ctrl;

  localparam int NAREG = 64;
  localparam int DW = 32;
  localparam int IMM_W = 12;
  localparam int GROUPS = NAREG / 4;
  localparam int BW = $clog2(GROUPS);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [3:0]        rd_idx;
  logic [DW-1:0]     rd_data;
  logic              wr_en;
  logic [3:0]        wr_idx;
  logic [DW-1:0]     wr_data;
  logic              op_valid;
  logic [2:0]        op_kind;
  logic [3:0]        op_reg;
  logic [IMM_W-1:0]  op_imm;
  logic [3:0]        op_rot;
  logic [1:0]        op_pc_hi;
  logic              ps_woe;
  logic              ps_excm;
  logic [1:0]        ps_callinc;
  logic [BW-1:0]     ps_owb;
  logic              op_done;
  logic [3:0]        exc_code;
  logic [DW-1:0]     ret_pc;
  logic [BW-1:0]     owb_save;
  logic              excm_set;
  logic [BW-1:0]     win_base;
  logic [GROUPS-1:0] win_start;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  regwin_ctrl #(.NAREG(NAREG), .DW(DW), .IMM_W(IMM_W)) i_regwin_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_data = 0; op_valid = 0; op_kind = 0;
    op_reg = 0; op_imm = 0; op_rot = 0; op_pc_hi = 0; ps_woe = 1; ps_excm = 0;
    ps_callinc = 0; ps_owb = 0; rd_idx = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] kind);
    @(negedge clk); op_valid = 1; op_kind = kind;
    @(negedge clk); op_valid = 0;
  endtask

  task automatic put(input int k, input logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_idx = k[3:0]; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(input int k, output logic [31:0] v);
    rd_idx = k[3:0]; #1; v = rd_data;
  endtask

  task automatic entry(input logic [1:0] ci, input logic [3:0] s, input int imm);
    ps_callinc = ci; op_reg = s; op_imm = IMM_W'(imm);
    issue(3'd1);
  endtask

  task automatic rotw(input int r);
    op_rot = r[3:0];
    issue(3'd3);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reset_dut();
    chk("R2 base", 32'(win_base), 0);
    chk("R2 bitmap", 32'(win_start), 1);
    chk("R2 done", 32'(op_done), 0);
    chk("R2 exc", 32'(exc_code), 0);
    chk("R2 excm", 32'(excm_set), 0);
    peek(7, v); chk("R2 reg", v, 0);
  endtask

  task automatic t_mapping();
    logic [31:0] v;
    reset_dut();
    for (int k = 0; k < 16; k++) put(k, 100 + k);
    rotw(1);
    chk("R11 rotate +1", 32'(win_base), 1);
    for (int k = 0; k < 16; k++) begin
      peek(k, v); chk("R1 read base1", v, (k < 12) ? 104 + k : 0);
    end
    rotw(-2);
    chk("R11 rotate -2 wraps", 32'(win_base), 15);
    for (int k = 0; k < 16; k++) begin
      peek(k, v); chk("R1 read base15", v, (k >= 4) ? 96 + k : 0);
    end
    ps_owb = 3; issue(3'd5);
    chk("R11 restore", 32'(win_base), 3);
    issue(3'd7);
    chk("R11 unused op base", 32'(win_base), 3);
    chk("R11 unused op exc", 32'(exc_code), 0);
  endtask

  task automatic t_done_pulse();
    reset_dut();
    issue(3'd0);
    chk("R12 done high", 32'(op_done), 1);
    @(negedge clk);
    chk("R12 done drops", 32'(op_done), 0);
    chk("R12 exc idle", 32'(exc_code), 0);
  endtask

  task automatic t_entry_illegal();
    reset_dut();
    entry(1, 4, 0);
    chk("R3 reg>3", 32'(exc_code), 1);
    chk("R3 base kept", 32'(win_base), 0);
    ps_woe = 0; entry(1, 1, 0);
    chk("R3 woe=0", 32'(exc_code), 1);
    ps_woe = 1; ps_excm = 1; entry(1, 1, 0);
    chk("R3 excm=1", 32'(exc_code), 1);
    chk("R3 bitmap kept", 32'(win_start), 1);
    chk("R3 no excm", 32'(excm_set), 0);
    ps_excm = 0;
  endtask

  task automatic t_entry_ok();
    logic [31:0] v;
    reset_dut();
    put(1, 1000);
    entry(1, 1, 2);
    chk("R4 exc", 32'(exc_code), 0);
    chk("R4 base", 32'(win_base), 1);
    chk("R4 bitmap", 32'(win_start), 3);
    peek(1, v); chk("R4 new sp", v, 984);
  endtask

  task automatic t_overflow();
    reset_dut();
    entry(1, 0, 0); entry(1, 0, 0); rotw(-3);
    entry(1, 0, 0);
    chk("R6 ovf4 code", 32'(exc_code), 3);
    chk("R5 ovf4 base", 32'(win_base), 0);
    chk("R5 ovf4 owb", 32'(owb_save), 15);
    chk("R5 ovf4 excm", 32'(excm_set), 1);
    chk("R5 ovf4 bitmap", 32'(win_start), 7);
    reset_dut();
    entry(2, 0, 0); rotw(-4);
    entry(2, 0, 0);
    chk("R6 ovf8 code", 32'(exc_code), 4);
    chk("R5 ovf8 n=2 base", 32'(win_base), 0);
    chk("R5 ovf8 owb", 32'(owb_save), 14);
    reset_dut();
    rotw(-1);
    entry(1, 0, 0);
    chk("R6 ovf12 code", 32'(exc_code), 5);
    chk("R5 ovf12 base", 32'(win_base), 0);
  endtask

  task automatic t_retw();
    reset_dut();
    entry(1, 0, 0);
    put(0, 32'h4000_0123);
    op_pc_hi = 2'b11; issue(3'd2);
    chk("R8 exc", 32'(exc_code), 0);
    chk("R8 ret_pc", ret_pc, 32'hC000_0123);
    chk("R8 base", 32'(win_base), 0);
    chk("R8 bitmap", 32'(win_start), 1);
    reset_dut();
    entry(1, 0, 0);
    put(0, 32'h8000_0000); issue(3'd2);
    chk("R7 m!=n", 32'(exc_code), 1);
    chk("R7 base kept", 32'(win_base), 1);
    put(0, 32'h0000_0010); issue(3'd2);
    chk("R7 n=0", 32'(exc_code), 1);
    put(0, 32'h4000_0000); ps_woe = 0; issue(3'd2);
    chk("R7 woe=0", 32'(exc_code), 1);
    chk("R7 bitmap kept", 32'(win_start), 3);
    ps_woe = 1;
  endtask

  task automatic t_underflow();
    for (int n = 1; n <= 3; n++) begin
      reset_dut();
      rotw(4);
      put(0, 32'(n) << 30);
      op_pc_hi = 2'b01; issue(3'd2);
      chk("R9 code", 32'(exc_code), 5 + n);
      chk("R9 base", 32'(win_base), 4 - n);
      chk("R9 owb", 32'(owb_save), 4);
      chk("R9 excm", 32'(excm_set), 1);
      chk("R9 bitmap", 32'(win_start), 1);
      chk("R8 ret_pc", ret_pc, 32'h4000_0000);
    end
  endtask

  task automatic t_movsp();
    reset_dut();
    issue(3'd4);
    chk("R10 alloca", 32'(exc_code), 2);
    chk("R10 base", 32'(win_base), 0);
    entry(1, 0, 0);
    issue(3'd4);
    chk("R10 legal", 32'(exc_code), 0);
  endtask

  task automatic t_write_blocked();
    logic [31:0] v;
    reset_dut();
    @(negedge clk);
    op_valid = 1; op_kind = 3'd4; wr_en = 1; wr_idx = 2; wr_data = 32'hDEAD;
    @(negedge clk);
    op_valid = 0; wr_en = 0;
    peek(2, v); chk("R13 write ignored", v, 0);
  endtask

  initial begin
    t_reset();
    t_mapping();
    t_done_pulse();
    t_entry_illegal();
    t_entry_ok();
    t_overflow();
    t_retw();
    t_underflow();
    t_movsp();
    t_write_blocked();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule